// File: doc/BRIEF.md
# Two-Output Programmable Clock Divider Chain

This block derives two divided clock waveforms from a single master clock. Each output path has its own power-of-two prescaler, selected by a 2-bit code. Output 0 is driven from its prescaler alone. Output 1 adds a second stage, a 10-bit programmable divider whose divisor is the programmed word plus two. A bypass control skips that second stage so the prescaler result drives output 1 directly.

Everything runs in the master clock domain. Each stage is a counter that advances on a tick from the stage before it. Each output is a registered level that follows the state of the counters with one cycle of latency. New select codes, divider words and the bypass setting are sampled only on the last master cycle of the current output period. Because of this, a settings change never shortens or stretches a pulse in the middle of a period. Each output has its own enable, which forces the output low without stopping its counters.

Top module: `clkdiv_chain`

## Requirements
- R1: The prescaler select code gives the divisor M: code 0 is divide by 1, code 1 by 2, code 2 by 4 and code 3 by 8. Output 0 repeats every M master cycles.
- R2: For a divisor D of 2 or more, the output is high for the first floor(D/2) master cycles of each period and low for the rest, so an odd divisor gives the shorter half high. An output whose total period is one master cycle is held high.
- R3: With the bypass low, output 1 repeats every M1*(W+2) master cycles, where W is the 10-bit divider word and M1 is the output-1 prescaler divisor. It is high for the first floor((W+2)/2)*M1 of those cycles.
- R4: With the bypass high, output 1 follows the output-1 prescaler alone and repeats every M1 cycles, with the R2 duty rule. The programmable divider then holds still.
- R5: Select codes, the divider word and the bypass bit are captured only on the last master cycle of the running output period. A change at any other time first shows in the period that starts after that capture.
- R6: While an output's enable is low, that output is low from the next cycle on. Its counters keep running, so when the enable returns the output resumes at the phase it would have had.
- R7: Synchronous active-high reset drives both outputs low. It clears all counters and loads divide-by-1 prescalers, a divider word of zero (divide by 2) and bypass off. The first output-1 period after reset is therefore two cycles long.
- R8: Each output is registered. The value seen in a cycle reflects the period phase of the previous cycle.
- R9: The largest divider word, 1023, gives a divisor of 1025 with no wrap or truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| out0_en | input | 1 | Enable for output 0 |
| out1_en | input | 1 | Enable for output 1 |
| p0_sel | input | 2 | Prescaler select code, path 0 |
| p1_sel | input | 2 | Prescaler select code, path 1 |
| n_word | input | 10 | Programmable divider word for path 1 (divisor = word + 2) |
| n_bypass | input | 1 | When high, output 1 skips the programmable divider |
| out0 | output | 1 | Divided clock, path 0 |
| out1 | output | 1 | Divided clock, path 1 |

## Verification
The risky overlap is a settings change arriving in the same cycle as the period wrap, which is exactly when the change is captured. It also matters when the bypass bit flips on the cycle where the prescaler wraps but the programmable divider does not. The stimulus rewrites the codes, word and bypass every few cycles with random timing, so many writes land on the wrap cycle and many land one cycle before or after it. A bench phase model captures settings only at its own period end, and each output is compared against it on every cycle. Any capture taken one cycle early or late shows up as a shifted edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PRE_SEL_W  = 2;
    localparam int PRE_CNT_W  = 4;
    localparam int N_W_DEF    = 10;
    localparam int N_OFFSET   = 2;

    typedef enum logic [PRE_SEL_W-1:0] {
        PRE_DIV1 = 2'd0,
        PRE_DIV2 = 2'd1,
        PRE_DIV4 = 2'd2,
        PRE_DIV8 = 2'd3
    } pre_sel_e;

    typedef struct packed {
        pre_sel_e sel;
        logic     bypass;
    } path_mode_t;

    function automatic logic [PRE_CNT_W-1:0] pre_divisor(input pre_sel_e sel);
        logic [PRE_CNT_W-1:0] one;
        one = PRE_CNT_W'(1);
        return one << sel;
    endfunction

endpackage

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
    parameter int            CW      = 4,
    parameter logic [CW-1:0] RST_DIV = CW'(1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] div_in,
    output logic [CW-1:0] div_cur,
    output logic          last,
    output logic          high
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] div_q;

    assign div_cur = div_q;
    assign last    = tick && (cnt == div_q - CW'(1));
    assign high    = (div_q == CW'(1)) ? 1'b1 : (cnt < (div_q >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= RST_DIV;
        end else begin
            if (tick) begin
                cnt <= last ? '0 : cnt + CW'(1);
            end
            if (load) begin
                div_q <= div_in;
            end
        end
    end

    p_cnt_below_div_r3: assert property (@(posedge clk) disable iff (rst)
        cnt < div_q);

    p_div_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(div_q));

    p_wrap_on_last_r1: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));

endmodule

// File: rtl/cdiv_path.sv
module cdiv_path
    import clkdiv_pkg::*;
#(
    parameter int N_W   = N_W_DEF,
    parameter bit HAS_N = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  path_mode_t     mode,
    input  logic [N_W-1:0] n_word,
    output logic           clk_out
);

    localparam int N_CNT_W = N_W + 1;

    logic                 boundary;
    logic                 wave;
    logic                 single;
    logic                 pre_last;
    logic                 pre_high;
    logic [PRE_CNT_W-1:0] pre_div_cur;

    cdiv_counter #(
        .CW      (PRE_CNT_W),
        .RST_DIV (PRE_CNT_W'(1))
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick    (1'b1),
        .load    (boundary),
        .div_in  (pre_divisor(mode.sel)),
        .div_cur (pre_div_cur),
        .last    (pre_last),
        .high    (pre_high)
    );

    generate
        if (HAS_N) begin : g_with_n
            logic               byp_q;
            logic               n_last;
            logic               n_high;
            logic [N_CNT_W-1:0] n_div_cur;
            logic [N_CNT_W-1:0] n_div_next;

            assign n_div_next = N_CNT_W'(n_word) + N_CNT_W'(N_OFFSET);

            cdiv_counter #(
                .CW      (N_CNT_W),
                .RST_DIV (N_CNT_W'(N_OFFSET))
            ) u_ndiv (
                .clk     (clk),
                .rst     (rst),
                .tick    (pre_last && !byp_q),
                .load    (boundary),
                .div_in  (n_div_next),
                .div_cur (n_div_cur),
                .last    (n_last),
                .high    (n_high)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    byp_q <= 1'b0;
                end else if (boundary) begin
                    byp_q <= mode.bypass;
                end
            end

            assign boundary = byp_q ? pre_last : n_last;
            assign wave     = byp_q ? pre_high : n_high;
            assign single   = byp_q && (pre_div_cur == PRE_CNT_W'(1));

            p_ndiv_min_two_r9: assert property (@(posedge clk) disable iff (rst)
                n_div_cur >= N_CNT_W'(N_OFFSET));

            p_bypass_n_quiet_r4: assert property (@(posedge clk) disable iff (rst)
                byp_q |-> !n_last);
        end else begin : g_pre_only
            logic unused_inputs;
            assign unused_inputs = ^{n_word, mode.bypass};
            assign boundary      = pre_last;
            assign wave          = pre_high;
            assign single        = (pre_div_cur == PRE_CNT_W'(1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_out <= 1'b0;
        end else begin
            clk_out <= en && wave;
        end
    end

    p_disabled_low_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !clk_out);

    p_div1_high_r2: assert property (@(posedge clk) disable iff (rst)
        (single && en) |=> clk_out);

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
    import clkdiv_pkg::*;
#(
    parameter int N_W = N_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 out0_en,
    input  logic                 out1_en,
    input  logic [PRE_SEL_W-1:0] p0_sel,
    input  logic [PRE_SEL_W-1:0] p1_sel,
    input  logic [N_W-1:0]       n_word,
    input  logic                 n_bypass,
    output logic                 out0,
    output logic                 out1
);

    path_mode_t mode0;
    path_mode_t mode1;

    assign mode0.sel    = pre_sel_e'(p0_sel);
    assign mode0.bypass = 1'b1;
    assign mode1.sel    = pre_sel_e'(p1_sel);
    assign mode1.bypass = n_bypass;

    cdiv_path #(
        .N_W   (N_W),
        .HAS_N (1'b0)
    ) u_path0 (
        .clk     (clk),
        .rst     (rst),
        .en      (out0_en),
        .mode    (mode0),
        .n_word  ('0),
        .clk_out (out0)
    );

    cdiv_path #(
        .N_W   (N_W),
        .HAS_N (1'b1)
    ) u_path1 (
        .clk     (clk),
        .rst     (rst),
        .en      (out1_en),
        .mode    (mode1),
        .n_word  (n_word),
        .clk_out (out1)
    );

    p_reset_low_r7: assert property (@(posedge clk)
        rst |=> (!out0 && !out1));

endmodule

// File: tb/clkdiv_chain_bench.sv
module clkdiv_chain_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       out0_en = 1'b1;
    logic       out1_en = 1'b1;
    logic [1:0] p0_sel = 2'd0;
    logic [1:0] p1_sel = 2'd0;
    logic [9:0] n_word = 10'd0;
    logic       n_bypass = 1'b0;
    logic       out0;
    logic       out1;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    string cur_req = "R7";

    // bench phase model
    int ph0 = 0, m0 = 1;
    int ph1 = 0, m1 = 1, d1 = 2;
    bit byp1 = 1'b0;
    bit exp0 = 1'b0, exp1 = 1'b0;

    always #5 clk = ~clk;

    clkdiv_chain u_clkdiv_chain (
        .clk      (clk),
        .rst      (rst),
        .out0_en  (out0_en),
        .out1_en  (out1_en),
        .p0_sel   (p0_sel),
        .p1_sel   (p1_sel),
        .n_word   (n_word),
        .n_bypass (n_bypass),
        .out0     (out0),
        .out1     (out1)
    );

    function automatic int pre_val(input logic [1:0] s);
        return 1 << s;
    endfunction

    function automatic int period1(input int m, input int d, input bit b);
        return b ? m : m * d;
    endfunction

    function automatic int high1(input int m, input int d, input bit b);
        if (b) return (m == 1) ? 1 : m / 2;
        return (d / 2) * m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ph0 = 0; m0 = 1;
            ph1 = 0; m1 = 1; d1 = 2; byp1 = 1'b0;
            exp0 = 1'b0; exp1 = 1'b0;
        end else begin
            exp0 = out0_en && (ph0 < ((m0 == 1) ? 1 : m0 / 2));
            exp1 = out1_en && (ph1 < high1(m1, d1, byp1));
            if (ph0 == m0 - 1) begin
                ph0 = 0; m0 = pre_val(p0_sel);
            end else ph0++;
            if (ph1 == period1(m1, d1, byp1) - 1) begin
                ph1 = 0; m1 = pre_val(p1_sel); d1 = int'(n_word) + 2; byp1 = n_bypass;
            end else ph1++;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out0 !== exp0) begin
                fails++;
                $display("FAIL %s out0 cycle %0d: actual %b expected %b", cur_req, cycles, out0, exp0);
            end
            checks++;
            if (out1 !== exp1) begin
                fails++;
                $display("FAIL %s out1 cycle %0d: actual %b expected %b", cur_req, cycles, out1, exp1);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1085));
        // R7: reset state, then default divide-by-2 on out1
        cur_req = "R7";
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(20);

        // R1: each prescaler code on path 0
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            p0_sel = 2'(s);
            wait_cycles(40);
        end

        // R2: odd divisors on path 1 (D = 3, 5, 7)
        cur_req = "R2";
        p1_sel = 2'd0;
        for (int w = 1; w < 6; w += 2) begin
            n_word = 10'(w);
            wait_cycles(30);
        end

        // R3: cascade of prescaler and divider
        cur_req = "R3";
        p1_sel = 2'd2; n_word = 10'd5;
        wait_cycles(90);
        p1_sel = 2'd3; n_word = 10'd2;
        wait_cycles(80);

        // R4: bypass with each prescaler code
        cur_req = "R4";
        n_bypass = 1'b1; n_word = 10'd7;
        for (int s = 0; s < 4; s++) begin
            p1_sel = 2'(s);
            wait_cycles(60);
        end
        n_bypass = 1'b0;

        // R5: settings rewritten at random points inside periods
        cur_req = "R5";
        for (int k = 0; k < 200; k++) begin
            p0_sel = 2'($urandom_range(3));
            p1_sel = 2'($urandom_range(3));
            n_word = 10'($urandom_range(6));
            n_bypass = 1'($urandom_range(1));
            wait_cycles($urandom_range(1, 4));
        end

        // R6: enables toggled while counters run
        cur_req = "R6";
        p0_sel = 2'd2; p1_sel = 2'd1; n_word = 10'd3; n_bypass = 1'b0;
        for (int k = 0; k < 60; k++) begin
            out0_en = 1'($urandom_range(1));
            out1_en = 1'($urandom_range(1));
            wait_cycles($urandom_range(1, 7));
        end
        out0_en = 1'b1; out1_en = 1'b1;

        // R8: registered output, checked across a full random sweep
        cur_req = "R8";
        for (int k = 0; k < 300; k++) begin
            p0_sel = 2'($urandom_range(3));
            p1_sel = 2'($urandom_range(3));
            n_word = 10'($urandom_range(40));
            n_bypass = ($urandom_range(3) == 0);
            out0_en = ($urandom_range(7) != 0);
            out1_en = ($urandom_range(7) != 0);
            wait_cycles($urandom_range(1, 60));
        end
        out0_en = 1'b1; out1_en = 1'b1;

        // R9: largest divider word
        cur_req = "R9";
        n_bypass = 1'b0; p1_sel = 2'd0; n_word = 10'd1023;
        wait_cycles(3200);
        p1_sel = 2'd3;
        wait_cycles(9000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule